// File: doc/BRIEF.md
# Overflow-Interrupt General-Purpose Timer

An up-counting timer with a small register interface. Software preloads the counter with all-ones minus N and sets the start bit. The counter then advances once per clock. On the clock edge where it sits at all-ones while running, an overflow event occurs. That event latches a status flag and, if enabled, drives the interrupt line.

With auto-reload set, the overflow edge copies the load register into the counter, which gives a periodic tick. With auto-reload clear, the counter wraps to zero and the start bit drops. Writing zero to both the counter and the load register, with start and auto-reload set, gives a free-running counter that can be read at any time.

Writes to the control, load and counter registers can be posted. In posted mode the value is staged, a per-register pending flag is raised, and the value lands a fixed number of clocks later. A further write to a register whose flag is still set is dropped. Reads are combinational from the read address.

Top module: `gpt_overflow_timer`

## Requirements
- R1: After reset every readable register reads zero, `irq` is low, and the counter stays at zero because it is stopped.
- R2: With the counter (address 2) written to all-ones minus N and the control register (address 0) written to 1 (bit 0 = start, bit 1 = auto-reload clear), the counter reads all-ones minus N plus j at the j-th edge after start takes effect. Status bit 0 (address 4) becomes 1 at edge N+1. At that edge the counter becomes 0 and stays 0, and the control register reads 0.
- R3: With control = 3 (start and auto-reload) and load register (address 1) = all-ones minus P, the counter repeats all-ones minus P up to all-ones with period P+1 clocks.
- R4: With load = 0, counter = 0 and control = 3, the counter reads j at the j-th edge after start.
- R5: Writing start = 0 stops the counter. It keeps the value reached at the edge of that write, and then holds it.
- R6: Status bit 0 (address 4) is set by each overflow event. Writing 1 to bit 0 clears it. Writing 0 has no effect. An overflow in the same cycle as a clear leaves the flag set.
- R7: `irq` is high exactly when status bit 0 and enable bit 0 (address 3) are both 1.
- R8: With mode bit 0 (address 5) set, a write to control, load or counter raises pending bit 0, 1 or 2 (address 6) respectively. The value takes effect, and the bit clears, SYNC_LAT edges after the write edge.
- R9: With mode bit 0 clear, a write takes effect at its own write edge, and no pending bit is raised.
- R10: A write to a register whose pending bit is set is ignored. The earlier staged value lands, and a write after landing is accepted.
- R11: If a counter write coincides with an overflow edge, a direct (non-posted) write loses to the overflow update, and a landing posted write wins over it. The status flag is set in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 3 | Write register address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Overflow interrupt |

## Verification
A corrupted counter shows up on the next read of address 2. It also moves the status edge, and with it `irq`, by the same number of clocks, so the per-cycle count sweeps over several preloads and periods catch it within one period. A stuck or miscounted pending countdown shows on address 6 and as a counter value landing one clock early or late in the posted sweep. A wrong priority at a reload/write collision leaves the wrong value in the counter on the very next read.

// File: rtl/gpt_pkg.sv
// Shared constants for the overflow timer: register addresses and the
// indices of the registers that accept posted writes.
package gpt_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_IRQEN = 3'd3;
    localparam logic [ADDR_W-1:0] A_IRQST = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd5;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd6;

    localparam int N_SLOTS   = 3;
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_LOAD = 1;
    localparam int SLOT_CNT  = 2;

    // Address of the register served by a posted-write slot.
    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            SLOT_CTRL: slot_addr = A_CTRL;
            SLOT_LOAD: slot_addr = A_LOAD;
            default:   slot_addr = A_COUNT;
        endcase
    endfunction
endpackage

// File: rtl/gpt_post_slot.sv
// Posted-write slot for one register.
// In direct mode an accepted write is presented in the same cycle.
// In posted mode the write is staged, pending is raised, and the staged
// value is presented LAT edges after the write edge, when pending drops.
// A write that arrives while pending is set is dropped.
// Assumes LAT >= 1.
module gpt_post_slot #(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         posted_mode,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    output logic         upd_valid,
    output logic [W-1:0] upd_data,
    output logic         pending
);
    localparam int DLY_W = $clog2(LAT + 1);

    logic [W-1:0]     stage_q;
    logic [DLY_W-1:0] dly_q;
    logic             pend_q;
    logic             accept;
    logic             land;

    assign accept = wr_hit && !pend_q;
    assign land   = pend_q && (dly_q == '0);

    // Stage posted writes and count down to the landing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            dly_q   <= '0;
            pend_q  <= 1'b0;
        end else if (accept && posted_mode) begin
            stage_q <= wr_data;
            dly_q   <= DLY_W'(LAT - 1);
            pend_q  <= 1'b1;
        end else if (land) begin
            pend_q  <= 1'b0;
        end else if (pend_q) begin
            dly_q   <= dly_q - 1'b1;
        end
    end

    // Present either the landing staged value or a direct write.
    assign upd_valid = land || (accept && !posted_mode);
    assign upd_data  = land ? stage_q : wr_data;
    assign pending   = pend_q;
endmodule

// File: rtl/gpt_count_core.sv
// Up-counter with overflow detection and reload.
// Overflow occurs on an edge where the counter is running at all-ones.
// A software update wins over the overflow update only when it comes
// from a landing posted write (upd_pending high).
module gpt_count_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         auto_reload,
    input  logic [W-1:0] reload_val,
    input  logic         upd_valid,
    input  logic         upd_pending,
    input  logic [W-1:0] upd_data,
    output logic [W-1:0] count,
    output logic         ovf_evt
);
    localparam logic [W-1:0] ALL1 = '1;

    logic [W-1:0] count_q;
    logic         sw_wins;

    assign ovf_evt = run && (count_q == ALL1);
    assign sw_wins = upd_valid && (upd_pending || !ovf_evt);

    // Advance, reload, or take a software value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (sw_wins) begin
            count_q <= upd_data;
        end else if (ovf_evt) begin
            count_q <= auto_reload ? reload_val : '0;
        end else if (run) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/gpt_overflow_timer.sv
// Overflow-interrupt timer top: register file, posted-write slots,
// counter core and interrupt flag. Reads are combinational.
// Assumes CNT_W >= 3 and SYNC_LAT >= 1.
module gpt_overflow_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int SYNC_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic               ctrl_start;
    logic               ctrl_ar;
    logic [CNT_W-1:0]   load_q;
    logic               irq_en_q;
    logic               ovf_stat;
    logic               posted_q;
    logic [N_SLOTS-1:0] upd_v;
    logic [N_SLOTS-1:0] pend_vec;
    logic [CNT_W-1:0]   upd_d [N_SLOTS];
    logic [CNT_W-1:0]   count_w;
    logic               ovf_evt;
    logic [CNT_W-1:0]   cnt_upd_d;
    logic [1:0]         ctrl_bits;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        gpt_post_slot #(.W(CNT_W), .LAT(SYNC_LAT)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .posted_mode (posted_q),
            .wr_hit      (wr_en && (wr_addr == slot_addr(g))),
            .wr_data     (wr_data),
            .upd_valid   (upd_v[g]),
            .upd_data    (upd_d[g]),
            .pending     (pend_vec[g])
        );
    end

    assign cnt_upd_d = upd_d[SLOT_CNT];
    assign ctrl_bits = upd_d[SLOT_CTRL][1:0];

    gpt_count_core #(.W(CNT_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (ctrl_start),
        .auto_reload (ctrl_ar),
        .reload_val  (load_q),
        .upd_valid   (upd_v[SLOT_CNT]),
        .upd_pending (pend_vec[SLOT_CNT]),
        .upd_data    (cnt_upd_d),
        .count       (count_w),
        .ovf_evt     (ovf_evt)
    );

    // Control bits: software update, or start dropped by one-shot overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_start <= 1'b0;
            ctrl_ar    <= 1'b0;
        end else if (upd_v[SLOT_CTRL]) begin
            ctrl_start <= ctrl_bits[0];
            ctrl_ar    <= ctrl_bits[1];
        end else if (ovf_evt && !ctrl_ar) begin
            ctrl_start <= 1'b0;
        end
    end

    // Load register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (upd_v[SLOT_LOAD]) begin
            load_q <= upd_d[SLOT_LOAD];
        end
    end

    // Direct-only registers: interrupt enable and posted mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            posted_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_IRQEN) irq_en_q <= wr_data[0];
            if (wr_addr == A_MODE)  posted_q <= wr_data[0];
        end
    end

    // Overflow status: set by overflow, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_stat <= 1'b0;
        end else if (ovf_evt) begin
            ovf_stat <= 1'b1;
        end else if (wr_en && (wr_addr == A_IRQST) && wr_data[0]) begin
            ovf_stat <= 1'b0;
        end
    end

    assign irq = ovf_stat && irq_en_q;

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {{(CNT_W-2){1'b0}}, ctrl_ar, ctrl_start};
            A_LOAD:  rd_data = load_q;
            A_COUNT: rd_data = count_w;
            A_IRQEN: rd_data = {{(CNT_W-1){1'b0}}, irq_en_q};
            A_IRQST: rd_data = {{(CNT_W-1){1'b0}}, ovf_stat};
            A_MODE:  rd_data = {{(CNT_W-1){1'b0}}, posted_q};
            A_PEND:  rd_data = {{(CNT_W-N_SLOTS){1'b0}}, pend_vec};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpt_overflow_timer_chk.sv
// Property checker for the overflow timer, attached with bind.
// Observes internal registers and the strobes between slots and core.
module gpt_overflow_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_start,
    input logic             ctrl_ar,
    input logic [CNT_W-1:0] load_q,
    input logic [CNT_W-1:0] count_w,
    input logic             ovf_evt,
    input logic             ovf_stat,
    input logic [2:0]       upd_v,
    input logic [2:0]       pend_vec,
    input logic [CNT_W-1:0] cnt_upd_d,
    input logic             irq,
    input logic             irq_en_q
);
    // R6
    ovf_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_stat);

    // R2
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ctrl_ar && !upd_v[0]) |=> !ctrl_start);

    // R3
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && ctrl_ar && !upd_v[2]) |=> (count_w == $past(load_q)));

    // R5
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_start && !upd_v[2]) |=> $stable(count_w));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en_q);

    // R11
    posted_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_v[2] && pend_vec[2]) |=> (count_w == $past(cnt_upd_d)));

    for (genvar i = 0; i < 3; i++) begin : g_pend
        // R8
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_vec[i] && !upd_v[i]) |=> pend_vec[i]);
    end
endmodule

bind gpt_overflow_timer gpt_overflow_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_start (ctrl_start),
    .ctrl_ar    (ctrl_ar),
    .load_q     (load_q),
    .count_w    (count_w),
    .ovf_evt    (ovf_evt),
    .ovf_stat   (ovf_stat),
    .upd_v      (upd_v),
    .pend_vec   (pend_vec),
    .cnt_upd_d  (cnt_upd_d),
    .irq        (irq),
    .irq_en_q   (irq_en_q)
);

// File: tb/gpt_overflow_timer_test.sv
module gpt_overflow_timer_test;
    localparam int LAT = 3;
    localparam logic [31:0] MAX = 32'hFFFF_FFFF;
    localparam logic [2:0] A_CTRL = 0, A_LOAD = 1, A_COUNT = 2, A_IRQEN = 3,
                           A_IRQST = 4, A_MODE = 5, A_PEND = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    int checks = 0;
    int errors = 0;

    gpt_overflow_timer #(.CNT_W(32), .SYNC_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write sampled at the next rising edge; returns at the following falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        tick(1);
        do_reset();
        // R1 reset state
        for (int a = 0; a < 7; a++) chk_rd("R1", 3'(a), 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        tick(3);
        chk_rd("R1 stopped", A_COUNT, 32'h0);

        // R2 one-shot expiry sweep
        for (int n = 0; n < 8; n++) begin
            do_reset();
            wr(A_COUNT, MAX - 32'(n));
            wr(A_CTRL, 32'h1);
            for (int j = 0; j <= n + 3; j++) begin
                chk_rd("R2 count", A_COUNT, (j <= n) ? MAX - 32'(n) + 32'(j) : 32'h0);
                chk_rd("R2 status", A_IRQST, (j >= n + 1) ? 32'h1 : 32'h0);
                chk("R7 masked", {31'b0, irq}, 32'h0);
                tick(1);
            end
            chk_rd("R2 ctrl", A_CTRL, 32'h0);
        end

        // R7 interrupt gating, R6 write-one-to-clear
        do_reset();
        wr(A_IRQEN, 32'h1);
        wr(A_COUNT, MAX);
        wr(A_CTRL, 32'h1);
        tick(1);
        chk("R7 on", {31'b0, irq}, 32'h1);
        wr(A_IRQEN, 32'h0);
        chk("R7 off", {31'b0, irq}, 32'h0);
        wr(A_IRQEN, 32'h1);
        chk("R7 again", {31'b0, irq}, 32'h1);
        wr(A_IRQST, 32'h0);
        chk_rd("R6 zero write", A_IRQST, 32'h1);
        wr(A_IRQST, 32'h1);
        chk_rd("R6 clear", A_IRQST, 32'h0);
        chk("R7 cleared", {31'b0, irq}, 32'h0);

        // R6 set wins over clear: period 2, overflow at edge k+2
        do_reset();
        wr(A_LOAD, MAX - 1);
        wr(A_COUNT, MAX - 1);
        wr(A_CTRL, 32'h3);
        wr(A_IRQST, 32'h1);
        chk_rd("R6 pre", A_IRQST, 32'h0);
        wr(A_IRQST, 32'h1);
        chk_rd("R6 set wins", A_IRQST, 32'h1);

        // R3 periodic reload sweep
        for (int pi = 0; pi < 4; pi++) begin
            int p;
            p = (pi == 3) ? 5 : pi;
            do_reset();
            wr(A_LOAD, MAX - 32'(p));
            wr(A_COUNT, MAX - 32'(p));
            wr(A_CTRL, 32'h3);
            for (int j = 0; j <= 3 * (p + 1); j++) begin
                chk_rd("R3 count", A_COUNT, MAX - 32'(p) + 32'(j % (p + 1)));
                tick(1);
            end
            chk_rd("R3 ctrl", A_CTRL, 32'h3);
        end

        // R4 free-running, then R5 stop
        do_reset();
        wr(A_LOAD, 32'h0);
        wr(A_COUNT, 32'h0);
        wr(A_CTRL, 32'h3);
        for (int j = 0; j <= 20; j++) begin
            chk_rd("R4 count", A_COUNT, 32'(j));
            tick(1);
        end
        wr(A_CTRL, 32'h0);
        chk_rd("R5 stop value", A_COUNT, 32'd22);
        tick(5);
        chk_rd("R5 hold", A_COUNT, 32'd22);

        // R9 direct write lands at its own edge
        do_reset();
        wr(A_COUNT, 32'h1234_5678);
        chk_rd("R9 count", A_COUNT, 32'h1234_5678);
        chk_rd("R9 pend", A_PEND, 32'h0);

        // R8 posted latency and pending flag
        do_reset();
        wr(A_MODE, 32'h1);
        wr(A_COUNT, 32'hCAFE_0001);
        for (int j = 0; j <= LAT + 1; j++) begin
            chk_rd("R8 pend", A_PEND, (j < LAT) ? 32'h4 : 32'h0);
            chk_rd("R8 count", A_COUNT, (j < LAT) ? 32'h0 : 32'hCAFE_0001);
            tick(1);
        end
        wr(A_LOAD, 32'h55);
        chk_rd("R8 load pend", A_PEND, 32'h2);
        chk_rd("R8 load old", A_LOAD, 32'h0);
        tick(LAT);
        chk_rd("R8 load landed", A_LOAD, 32'h55);

        // R10 hold-off of a second write while pending
        do_reset();
        wr(A_MODE, 32'h1);
        wr(A_COUNT, 32'h0000_0AAA);
        wr(A_COUNT, 32'h0000_0BBB);
        tick(LAT);
        chk_rd("R10 first kept", A_COUNT, 32'h0000_0AAA);
        chk_rd("R10 pend clear", A_PEND, 32'h0);
        wr(A_COUNT, 32'h0000_0CCC);
        tick(LAT);
        chk_rd("R10 later write", A_COUNT, 32'h0000_0CCC);

        // R11 direct write at overflow edge loses to reload
        do_reset();
        wr(A_LOAD, MAX - 5);
        wr(A_COUNT, MAX - 2);
        wr(A_CTRL, 32'h3);
        tick(2);
        wr(A_COUNT, 32'h0000_0777);
        chk_rd("R11 direct loses", A_COUNT, MAX - 5);
        chk_rd("R11 status direct", A_IRQST, 32'h1);

        // R11 posted write landing at overflow edge wins
        do_reset();
        wr(A_LOAD, MAX - 9);
        wr(A_COUNT, MAX - 5);
        wr(A_CTRL, 32'h3);
        wr(A_MODE, 32'h1);
        tick(1);
        wr(A_COUNT, 32'h0000_0999);
        tick(2);
        chk_rd("R11 pre", A_COUNT, MAX);
        tick(1);
        chk_rd("R11 posted wins", A_COUNT, 32'h0000_0999);
        chk_rd("R11 status posted", A_IRQST, 32'h1);
        tick(1);
        chk_rd("R11 continues", A_COUNT, 32'h0000_099A);

        report();
        $finish;
    end
endmodule